// File: doc/BRIEF.md
# Banked GPIO Configuration Register Block

This block is the general-purpose I/O function reached through an indexed configuration register space. A host places an 8-bit register index on the bus together with a write or read strobe; the block answers only while its logical device is the one currently selected, which the surrounding configuration logic signals with a single flag. Behind the index space sit up to eight pin banks. Each bank owns four consecutive registers: one that sets each pin's direction, one that holds the value to drive, one that reports the pin levels, and one that chooses how each output drives.

A pin can drive in one of two ways. In push-pull mode it drives its latched value in both directions. In open-drain mode it only ever pulls low, and it releases the pad when the latched value is 1. The block drives a level and an output enable for every pin; the pad cells combine them. Banks may wire fewer than eight pins, and the missing bits are inert. Pin levels pass through a two-flop synchronizer before software can read them.

Top module: `gpio_cfg_banks`

## Requirements
- R1: After reset every pin is an input (all of `pin_oe` low), every output latch is 0, every mode bit is 0 (open-drain), and reads of the direction, latch and mode registers return 0.
- R2: Bank k has its register group at index 0xF0 - 0x10*k. Offset 0 is the direction register: bit value 1 makes the pin an output and 0 makes it an input. The value written reads back.
- R3: Offset 1 is the output latch, and it reads back. When a pin is an output in push-pull mode, `pin_oe` is 1 and `pin_out` equals the latch bit.
- R4: When a pin is an output in open-drain mode, a latch bit of 0 gives `pin_oe`=1 and `pin_out`=0, and a latch bit of 1 gives `pin_oe`=0. An open-drain pin never drives `pin_out` high.
- R5: Offset 2 returns the bank's pin levels after a two-flop synchronizer. A level applied to `pin_in` shows up in a read whose strobe comes two or more clock edges after the change.
- R6: Offset 3 is the output-mode register: bit value 0 selects open-drain and 1 selects push-pull. The value written reads back.
- R7: While `dev_sel` is low, writes change no register and reads return 0x00.
- R8: In a bank with fewer than 8 pins, the bits above its pin count read 0 in every register, ignore writes, and never assert `pin_oe`.
- R9: Indexes that fall outside every bank's four registers (offsets 4 to 15 of a group, and groups below the lowest bank) read 0x00, and writes to them have no effect.
- R10: A write changes only the addressed register of the addressed bank. Offset 2 is read-only, so writing it changes nothing.
- R11: `rd_data` updates on the clock edge that samples `rd_stb` and keeps its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel | input | 1 | High while the GPIO logical device is selected |
| reg_idx | input | 8 | Register index |
| wr_data | input | 8 | Write data |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| pin_in | input | 8*NUM_BANKS | Pad input levels, 8 bits per bank, bank 0 lowest |
| rd_data | output | 8 | Registered read data |
| pin_out | output | 8*NUM_BANKS | Level to drive on each pad |
| pin_oe | output | 8*NUM_BANKS | Output enable for each pad |

## Verification
The hardest case is a single-bit read-modify-write on one bank while other banks and the other registers of the same bank hold values. Only this case shows that a write lands in exactly one place. The stimulus first sets non-trivial direction and mode patterns, then rewrites one latch bit. It checks every bank's `pin_oe` slice and reads back the neighbouring registers. Partial banks are another hard case: the stimulus drives all-ones on their pins and writes all-ones to their registers, so any bit above the pin count that leaks through shows up in the readback and in the enables.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

    typedef struct packed {
        logic [7:0] dir;
        logic [7:0] lat;
        logic [7:0] mode;
    } bank_regs_t;

    typedef enum logic [1:0] {
        OFS_DIR  = 2'd0,
        OFS_LAT  = 2'd1,
        OFS_PINS = 2'd2,
        OFS_MODE = 2'd3
    } reg_ofs_e;

    function automatic logic [7:0] pin_mask(input int unsigned cnt);
        logic [8:0] m;
        m = (9'd1 << cnt) - 9'd1;
        return m[7:0];
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stable;

    // R5
    sync_second_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out == $past(s_q.meta));

endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice
    import gpio_cfg_pkg::*;
#(
    parameter int         PIN_CNT = 8,
    parameter logic [7:0] BASE    = 8'hF0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic [7:0] reg_idx,
    input  logic [7:0] wr_data,
    input  logic       wr_stb,
    input  logic [7:0] pins_sync,
    output logic [7:0] rd_val,
    output logic [7:0] pin_out,
    output logic [7:0] pin_oe
);
    localparam logic [7:0] MASK = pin_mask(PIN_CNT);

    bank_regs_t regs_d, regs_q;
    logic       hit;
    reg_ofs_e   ofs;

    assign hit = sel && (reg_idx[7:4] == BASE[7:4]) && (reg_idx[3:2] == 2'b00);
    assign ofs = reg_ofs_e'(reg_idx[1:0]);

    always_comb begin
        regs_d = regs_q;
        if (wr_stb && hit) begin
            case (ofs)
                OFS_DIR:  regs_d.dir  = wr_data & MASK;
                OFS_LAT:  regs_d.lat  = wr_data & MASK;
                OFS_MODE: regs_d.mode = wr_data & MASK;
                default:  regs_d      = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_val = '0;
        if (hit) begin
            case (ofs)
                OFS_DIR:  rd_val = regs_q.dir;
                OFS_LAT:  rd_val = regs_q.lat;
                OFS_PINS: rd_val = pins_sync & MASK;
                OFS_MODE: rd_val = regs_q.mode;
                default:  rd_val = '0;
            endcase
        end
    end

    // push-pull drives the latch both ways; open-drain only pulls low
    assign pin_oe  = regs_q.dir & (regs_q.mode | ~regs_q.lat) & MASK;
    assign pin_out = regs_q.dir & regs_q.mode & regs_q.lat & MASK;

    // R1
    bank_reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (regs_q == '0));
    // R7
    deselected_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !sel) |=> $stable(regs_q));
    // R10
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && sel && reg_idx == (BASE | 8'h02)) |=> $stable(regs_q));
    // R8
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs_q.dir | regs_q.lat | regs_q.mode | pin_oe) & ~MASK) == 8'h00);
    // R4
    drive_high_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == 8'h00);

endmodule

// File: rtl/gpio_cfg_banks.sv
module gpio_cfg_banks
    import gpio_cfg_pkg::*;
#(
    parameter int                         NUM_BANKS = 8,
    parameter logic [7:0]                 TOP_BASE  = 8'hF0,
    parameter logic [7:0]                 STRIDE    = 8'h10,
    parameter logic [NUM_BANKS-1:0][3:0]  BANK_PINS = {4'd8, 4'd8, 4'd5, 4'd8, 4'd8, 4'd8, 4'd7, 4'd7}
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dev_sel,
    input  logic [7:0]             reg_idx,
    input  logic [7:0]             wr_data,
    input  logic                   wr_stb,
    input  logic                   rd_stb,
    input  logic [8*NUM_BANKS-1:0] pin_in,
    output logic [7:0]             rd_data,
    output logic [8*NUM_BANKS-1:0] pin_out,
    output logic [8*NUM_BANKS-1:0] pin_oe
);
    localparam int PIN_W = 8 * NUM_BANKS;

    logic [PIN_W-1:0] pins_sync;
    logic [7:0]       bank_rd [NUM_BANKS];
    logic [7:0]       rd_any;
    logic [7:0]       rd_d, rd_q;

    gpio_in_sync #(.WIDTH(PIN_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [7:0] BBASE = TOP_BASE - 8'(b * int'(STRIDE));
        gpio_bank_slice #(
            .PIN_CNT (int'(BANK_PINS[b])),
            .BASE    (BBASE)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (dev_sel),
            .reg_idx   (reg_idx),
            .wr_data   (wr_data),
            .wr_stb    (wr_stb),
            .pins_sync (pins_sync[b*8 +: 8]),
            .rd_val    (bank_rd[b]),
            .pin_out   (pin_out[b*8 +: 8]),
            .pin_oe    (pin_oe[b*8 +: 8])
        );
    end

    always_comb begin
        rd_any = '0;
        for (int b = 0; b < NUM_BANKS; b++) rd_any = rd_any | bank_rd[b];
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_stb) rd_d = rd_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
    // R7
    rd_deselected_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !dev_sel) |=> (rd_data == 8'h00));
    // R1
    top_reset_oe_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0));

endmodule

// File: tb/gpio_cfg_banks_bench.sv
module gpio_cfg_banks_bench;
    localparam int NB = 8;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          dev_sel = 1;
    logic [7:0]    reg_idx = '0;
    logic [7:0]    wr_data = '0;
    logic          wr_stb = 0;
    logic          rd_stb = 0;
    logic [8*NB-1:0] pin_in = '0;
    logic [7:0]    rd_data;
    logic [8*NB-1:0] pin_out, pin_oe;

    int checks = 0;
    int failures = 0;
    rd_item_t sb[$];
    logic rd_seen = 0;
    logic [7:0] held;

    always #5 clk = ~clk;

    gpio_cfg_banks u_gpio_cfg_banks (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .reg_idx(reg_idx),
        .wr_data(wr_data), .wr_stb(wr_stb), .rd_stb(rd_stb), .pin_in(pin_in),
        .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [7:0] base_of(input int b);
        return 8'(8'hF0 - 16 * b);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] val);
        @(negedge clk);
        reg_idx = idx; wr_data = val; wr_stb = 1;
        @(negedge clk);
        wr_stb = 0;
    endtask

    task automatic rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        rd_item_t it;
        @(negedge clk);
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        reg_idx = idx; rd_stb = 1;
        @(negedge clk);
        rd_stb = 0;
    endtask

    task automatic pins(input int b, input logic [7:0] oe, input logic [7:0] out, input string tag);
        check({tag, " oe"}, 64'(pin_oe[b*8 +: 8]), 64'(oe));
        check({tag, " out"}, 64'(pin_out[b*8 +: 8]), 64'(out));
    endtask

    // monitor: compare the registered read result one edge after the strobe
    always @(posedge clk) rd_seen <= rd_stb;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb.size() == 0) begin
                checks++; failures++;
                $display("FAIL scoreboard empty actual=%0h expected=none", rd_data);
            end else begin
                rd_item_t it;
                it = sb.pop_front();
                check(it.tag, 64'(rd_data), 64'(it.exp));
            end
        end
    end

    initial begin
        #1ms;
        failures++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] oe_snap;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 all oe", pin_oe, '0);
        rd(base_of(0), 8'h00, "R1 dir");
        rd(base_of(0) + 1, 8'h00, "R1 latch");
        rd(base_of(0) + 3, 8'h00, "R1 mode");

        // R2 direction on bank 2 (0xD0)
        wr(8'hD0, 8'hA5);
        rd(8'hD0, 8'hA5, "R2 dir readback");
        pins(2, 8'hA5, 8'h00, "R4 od latch0");

        // R4 open-drain with latch ones releases
        wr(8'hD1, 8'h0F);
        pins(2, 8'hA0, 8'h00, "R4 od latch1 release");

        // R6 / R3 push-pull
        wr(8'hD3, 8'hFF);
        rd(8'hD3, 8'hFF, "R6 mode readback");
        pins(2, 8'hA5, 8'h05, "R3 push-pull");

        // R10 single-bit RMW on latch
        rd(8'hD1, 8'h0F, "R3 latch readback");
        wr(8'hD1, 8'h0F | 8'h40);
        rd(8'hD1, 8'h4F, "R10 rmw latch");
        rd(8'hD0, 8'hA5, "R10 dir intact");
        rd(8'hD3, 8'hFF, "R10 mode intact");
        rd(8'hC0, 8'h00, "R10 other bank intact");
        pins(2, 8'hA5, 8'h05, "R10 pins after rmw");
        pins(3, 8'h00, 8'h00, "R10 neighbour pins");

        // R5 input synchronizer
        pin_in[1*8 +: 8] = 8'h3C;
        pin_in[2*8 +: 8] = 8'h99;
        pin_in[5*8 +: 8] = 8'hFF;
        repeat (2) @(negedge clk);
        rd(8'hE2, 8'h3C, "R5 bank1 pins");
        rd(8'hA2, 8'h1F, "R8 bank5 pins masked");
        wr(8'hD2, 8'h00);
        rd(8'hD2, 8'h99, "R10 status read-only");
        rd(8'hD0, 8'hA5, "R10 status write no side effect");

        // R8 partial bank 5 (0xA0), 5 pins
        wr(8'hA0, 8'hFF);
        rd(8'hA0, 8'h1F, "R8 dir masked");
        pins(5, 8'h1F, 8'h00, "R8 oe masked");
        wr(8'hA3, 8'hFF);
        wr(8'hA1, 8'hFF);
        pins(5, 8'h1F, 8'h1F, "R8 push-pull masked");

        // R7 deselected
        dev_sel = 0;
        wr(8'hD0, 8'h00);
        rd(8'hD0, 8'h00, "R7 read deselected");
        dev_sel = 1;
        rd(8'hD0, 8'hA5, "R7 write ignored");

        // R9 decode holes and lowest bank
        oe_snap = pin_oe;
        wr(8'h70, 8'hFF);
        wr(8'hD4, 8'hFF);
        wr(8'hDF, 8'hFF);
        check("R9 hole writes no effect", pin_oe, oe_snap);
        rd(8'hD4, 8'h00, "R9 read offset4");
        rd(8'h70, 8'h00, "R9 read below banks");
        wr(8'h80, 8'h01);
        rd(8'h80, 8'h01, "R2 lowest bank base");
        pins(7, 8'h01, 8'h00, "R4 bank7 od");

        // R11 hold
        rd(8'hE2, 8'h3C, "R11 read");
        held = rd_data;
        repeat (4) @(negedge clk);
        check("R11 hold", 64'(rd_data), 64'(8'h3C));
        check("R11 hold stable", 64'(rd_data), 64'(held));

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule